// File: doc/BRIEF.md
# Stereo-Unpacking Audio Receive FIFO

This block sits between an audio serial-port deserializer and a register read port. The deserializer hands over one channel sample per push. A reader takes entries out again in the shape set by a mode input. In interleaved stereo each read yields one channel sample, left and right taking turns. The two packed stereo modes return a left/right pair in one 32-bit word, with lanes of either 16 or 8 bits. In mono each read yields one sample.

Occupancy is counted in channel samples, and a mono sample takes two slots, like a pair. The block keeps a programmable threshold and raises a service request while the occupancy is strictly above it. An odd occupancy flags a pair whose right half is still waiting to be read. A push that finds no room is dropped and sets a sticky overrun flag.

The read word is presented combinationally from the stored entries. A read strobe consumes the entries behind that word on the next clock edge.

Top module: `rx_stereo_fifo`

## Requirements
- R1: The store holds at most 16 channel samples, and `level_o` reports the current count. After reset the level is 0, the overrun flag is 0 and the threshold is 16.
- R2: With mode 2'b00 (interleaved), each push adds one entry and `rd_data_o` shows the oldest entry. A pop removes exactly one entry, so successive reads return samples in push order (left, then right).
- R3: With mode 2'b01 (16-bit packed), `rd_data_o` carries the oldest entry's bits 15:0 in bits 15:0 and the next entry's bits 15:0 in bits 31:16. A pop removes two entries.
- R4: With mode 2'b10 (8-bit packed), `rd_data_o` carries the oldest entry's bits 7:0 in bits 7:0, the next entry's bits 7:0 in bits 15:8, and zero in bits 31:16. A pop removes two entries.
- R5: With mode 2'b11 (mono), a push stores the sample as a pair and adds 2 to the level. `rd_data_o` shows that sample, and a pop removes two entries.
- R6: When the level is below what one read needs (1 entry in interleaved mode, 2 in the other modes), `rd_data_o` is zero and a pop leaves the level unchanged.
- R7: `req_o` is high exactly while the level is strictly greater than the threshold with its bit 0 taken as 0. A threshold of 0 requests on any data, and a threshold of 16 never requests.
- R8: `limit_o` returns threshold bits 4:1 as last written (or as reset) with bit 0 always reading 1.
- R9: `odd_o` is high exactly when the level is odd.
- R10: A push with less free room than it needs (1 entry, or 2 in mono) is discarded and leaves the level unchanged. It sets `overrun_o`, which then stays high until reset.
- R11: The room check for a push uses the level before any pop in the same cycle. A push and a pop together on a full store therefore drop the push and lower the level by the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 interleaved, 01 packed 16, 10 packed 8, 11 mono |
| push_i | input | 1 | Deserializer delivers one sample |
| push_data_i | input | 32 | Channel sample being delivered |
| pop_i | input | 1 | Read strobe; consumes the entries shown on rd_data_o |
| rd_data_o | output | 32 | Read word for the current mode |
| limit_we_i | input | 1 | Threshold write strobe |
| limit_wdata_i | input | 5 | New threshold value |
| limit_o | output | 5 | Threshold readback, bit 0 fixed at 1 |
| level_o | output | 5 | Occupancy in channel samples |
| req_o | output | 1 | Service request |
| odd_o | output | 1 | Partially read pair |
| overrun_o | output | 1 | Sticky dropped-push flag |

## Verification
The bench uses the default depth of 16 with 32-bit samples. That keeps the full-store boundary a few pushes away, so random traffic reaches overruns, odd levels and the "threshold 16 never requests" case. Packed-mode lanes of 16 and 8 bits leave upper bits in every sample that must not leak into the read word. Random phases switch mode on a populated store and write odd thresholds, which exercises misaligned pairs and the ignored threshold bit 0.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL   = 2'd0,
    MODE_PACK16 = 2'd1,
    MODE_PACK8  = 2'd2,
    MODE_MONO   = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int SW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    push_n_i,
  input  logic [SW-1:0] wr_data_i,
  input  logic [1:0]    pop_n_i,
  output logic [SW-1:0] head_o,
  output logic [SW-1:0] next_o
);
  logic [SW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp1, rp1;

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] p, logic [1:0] n);
    logic [AW:0] s;
    s = {1'b0, p} + (AW+1)'(n);
    if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
    return s[AW-1:0];
  endfunction

  assign wp1 = wrap_add(wp_q, 2'd1);
  assign rp1 = wrap_add(rp_q, 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wrap_add(wp_q, push_n_i);
      rp_q <= wrap_add(rp_q, pop_n_i);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    assign hit = (push_n_i != 2'd0 && wp_q == AW'(i)) ||
                 (push_n_i == 2'd2 && wp1 == AW'(i));
    always_ff @(posedge clk_i) begin
      if (hit) mem_q[i] <= wr_data_i;
    end
  end

  assign head_o = mem_q[rp_q];
  assign next_o = mem_q[rp1];
endmodule

// File: rtl/rxf_unpack.sv
module rxf_unpack
  import rxf_pkg::*;
#(
  parameter int SW    = 32,
  parameter int LW    = 5,
  localparam int HALF = SW / 2,
  localparam int QTR  = SW / 4
) (
  input  rx_mode_e      mode_i,
  input  logic [LW-1:0] level_i,
  input  logic [SW-1:0] head_i,
  input  logic [SW-1:0] next_i,
  input  logic          pop_i,
  output logic [SW-1:0] data_o,
  output logic [1:0]    pop_n_o
);
  logic [LW-1:0] need;
  logic          avail;

  assign need  = (mode_i == MODE_DUAL) ? LW'(1) : LW'(2);
  assign avail = level_i >= need;

  always_comb begin
    data_o = '0;
    if (avail) begin
      unique case (mode_i)
        MODE_DUAL:   data_o = head_i;
        MODE_PACK16: data_o = {next_i[HALF-1:0], head_i[HALF-1:0]};
        MODE_PACK8:  data_o = {{HALF{1'b0}}, next_i[QTR-1:0], head_i[QTR-1:0]};
        default:     data_o = head_i;
      endcase
    end
  end

  assign pop_n_o = (pop_i && avail) ? need[1:0] : 2'd0;
endmodule

// File: rtl/rxf_svc.sv
module rxf_svc #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [LW-1:0] wdata_i,
  input  logic [LW-1:0] level_i,
  output logic [LW-1:0] limit_o,
  output logic          req_o
);
  localparam logic [LW-1:0] RST_LIM = LW'(DEPTH);
  logic [LW-1:1] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lim_q <= RST_LIM[LW-1:1];
    else if (we_i) lim_q <= wdata_i[LW-1:1];
  end

  // bit 0 carries no meaning: compare as even, read back as 1
  assign req_o   = level_i > {lim_q, 1'b0};
  assign limit_o = {lim_q, 1'b1};
endmodule

// File: rtl/rx_stereo_fifo.sv
module rx_stereo_fifo
  import rxf_pkg::*;
#(
  parameter int SW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          push_i,
  input  logic [SW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [SW-1:0] rd_data_o,
  input  logic          limit_we_i,
  input  logic [LW-1:0] limit_wdata_i,
  output logic [LW-1:0] limit_o,
  output logic [LW-1:0] level_o,
  output logic          req_o,
  output logic          odd_o,
  output logic          overrun_o
);
  rx_mode_e      mode;
  logic [LW-1:0] lvl_q;
  logic          ovr_q;
  logic [1:0]    push_need, push_n, pop_n;
  logic          room;
  logic [SW-1:0] head, next;

  assign mode      = rx_mode_e'(mode_i);
  assign push_need = (mode == MODE_MONO) ? 2'd2 : 2'd1;
  // room judged on the pre-pop level
  assign room      = ((LW+1)'(DEPTH) - {1'b0, lvl_q}) >= (LW+1)'(push_need);
  assign push_n    = (push_i && room) ? push_need : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      lvl_q <= LW'({1'b0, lvl_q} + (LW+1)'(push_n) - (LW+1)'(pop_n));
      if (push_i && !room) ovr_q <= 1'b1;
    end
  end

  rxf_store #(.SW(SW), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_n_i  (push_n),
    .wr_data_i (push_data_i),
    .pop_n_i   (pop_n),
    .head_o    (head),
    .next_o    (next)
  );

  rxf_unpack #(.SW(SW), .LW(LW)) u_unpack (
    .mode_i  (mode),
    .level_i (lvl_q),
    .head_i  (head),
    .next_i  (next),
    .pop_i   (pop_i),
    .data_o  (rd_data_o),
    .pop_n_o (pop_n)
  );

  rxf_svc #(.DEPTH(DEPTH), .LW(LW)) u_svc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (limit_we_i),
    .wdata_i (limit_wdata_i),
    .level_i (lvl_q),
    .limit_o (limit_o),
    .req_o   (req_o)
  );

  assign level_o   = lvl_q;
  assign odd_o     = lvl_q[0];
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rx_stereo_fifo_chk.sv
module rx_stereo_fifo_chk #(
  parameter int SW    = 32,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          push_i,
  input logic          pop_i,
  input logic [SW-1:0] rd_data_o,
  input logic [LW-1:0] limit_o,
  input logic [LW-1:0] level_o,
  input logic          req_o,
  input logic          overrun_o
);
  a_r1_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r10_full_push_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && level_o == LW'(DEPTH)) |=> overrun_o);

  a_r6_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (rd_data_o == '0));

  a_r7_req_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (level_o != '0));

  a_r8_limit_lsb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_o[0]);

  a_r2_dual_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && pop_i && !push_i && level_o != '0)
      |=> (level_o == $past(level_o) - LW'(1)));
endmodule

bind rx_stereo_fifo rx_stereo_fifo_chk #(.SW(SW), .DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .rd_data_o (rd_data_o),
  .limit_o   (limit_o),
  .level_o   (level_o),
  .req_o     (req_o),
  .overrun_o (overrun_o)
);

// File: tb/rx_stereo_fifo_test.sv
`timescale 1ns/1ps
module rx_stereo_fifo_test;
  localparam int SW = 32;
  localparam int DEPTH = 16;
  localparam int LW = 5;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    mode = 0;
  logic          push = 0;
  logic [SW-1:0] push_data = 0;
  logic          pop = 0;
  logic [SW-1:0] rd_data;
  logic          lim_we = 0;
  logic [LW-1:0] lim_wd = 0;
  logic [LW-1:0] lim_rd, level;
  logic          req, odd, ovr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [SW-1:0] q[$];
  int            m_lim;
  bit            m_ovr;

  always #2 clk = ~clk;

  rx_stereo_fifo #(.SW(SW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .push_i(push),
    .push_data_i(push_data), .pop_i(pop), .rd_data_o(rd_data),
    .limit_we_i(lim_we), .limit_wdata_i(lim_wd), .limit_o(lim_rd),
    .level_o(level), .req_o(req), .odd_o(odd), .overrun_o(ovr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int need_of(logic [1:0] m);
    return (m == 2'd0) ? 1 : 2;
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] m);
    if (q.size() < need_of(m)) return 32'h0;
    case (m)
      2'd0: return q[0];
      2'd1: return {q[1][15:0], q[0][15:0]};
      2'd2: return {16'h0, q[1][7:0], q[0][7:0]};
      default: return q[0];
    endcase
  endfunction

  function automatic string rd_tag(logic [1:0] m);
    if (q.size() < need_of(m)) return "R6";
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_status();
    chk("R1 level", 32'(level), 32'(q.size()));
    chk("R9 odd", 32'(odd), 32'(q.size() % 2));
    chk("R7 req", 32'(req), 32'(q.size() > (m_lim & 30)));
    chk("R8 limit", 32'(lim_rd), 32'(m_lim | 1));
    chk("R10 overrun", 32'(ovr), 32'(m_ovr));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    push = 0; pop = 0; lim_we = 0;
    q.delete();
    m_lim = 16;
    m_ovr = 0;
    #3;
    rst_n = 1;
    @(posedge clk); #1;
  endtask

  // one clock: drive at negedge, check read word, then status after edge
  task automatic cyc(logic [1:0] m, bit ps, logic [31:0] d, bit pp,
                     bit lw = 0, logic [4:0] lv = 0);
    int pneed, rneed;
    bit room;
    @(negedge clk);
    mode = m; push = ps; push_data = d; pop = pp; lim_we = lw; lim_wd = lv;
    #0.5;
    chk(rd_tag(m), rd_data, exp_rd(m));
    pneed = (m == 2'd3) ? 2 : 1;
    rneed = need_of(m);
    room  = (DEPTH - q.size()) >= pneed;
    @(posedge clk); #1;
    push = 0; pop = 0; lim_we = 0;
    if (pp && q.size() >= rneed) repeat (rneed) void'(q.pop_front());
    if (ps) begin
      if (room) repeat (pneed) q.push_back(d);
      else m_ovr = 1;
    end
    if (lw) m_lim = lv & 30;
    check_status();
  endtask

  initial begin
    do_reset();
    // R1 / R8 reset state
    chk("R1 reset level", 32'(level), 0);
    chk("R8 reset limit", 32'(lim_rd), 32'd17);
    chk("R10 reset overrun", 32'(ovr), 0);
    chk("R6 empty read", rd_data, 0);

    // R2 interleaved left then right
    cyc(2'd0, 1, 32'hAAAA_0001, 0);
    cyc(2'd0, 1, 32'hBBBB_0002, 0);
    cyc(2'd0, 0, 0, 1);
    chk("R9 odd after left read", 32'(odd), 1);
    cyc(2'd0, 0, 0, 1);
    chk("R2 empty after pair", 32'(level), 0);

    // R3 packed 16
    cyc(2'd1, 1, 32'h1234_5678, 0);
    cyc(2'd1, 0, 0, 1);            // only one entry: R6 ignored pop
    chk("R6 pop ignored", 32'(level), 1);
    cyc(2'd1, 1, 32'h9ABC_DEF0, 0);
    cyc(2'd1, 0, 0, 1);

    // R4 packed 8
    cyc(2'd2, 1, 32'h1111_22C3, 0);
    cyc(2'd2, 1, 32'h3333_44D5, 0);
    cyc(2'd2, 0, 0, 1);

    // R5 mono
    cyc(2'd3, 1, 32'hCAFE_F00D, 0);
    chk("R5 mono counts two", 32'(level), 2);
    cyc(2'd3, 0, 0, 1);
    chk("R5 mono pop two", 32'(level), 0);

    // R7 threshold 0 and 16, odd written value
    cyc(2'd0, 0, 0, 0, 1, 5'd0);
    cyc(2'd0, 1, 32'h5, 0);
    chk("R7 limit0 any data", 32'(req), 1);
    cyc(2'd0, 0, 0, 1, 1, 5'd5);
    chk("R8 odd limit readback", 32'(lim_rd), 5);
    cyc(2'd0, 0, 0, 0, 1, 5'd16);
    for (int i = 0; i < 16; i++) cyc(2'd0, 1, 32'(i * 3 + 7), 0);
    chk("R7 limit16 never", 32'(req), 0);
    // R10 push when full
    cyc(2'd0, 1, 32'hDEAD, 0);
    chk("R10 full push dropped", 32'(level), 16);
    chk("R10 overrun set", 32'(ovr), 1);
    // R11 push + pop on full
    do_reset();
    for (int i = 0; i < 16; i++) cyc(2'd0, 1, 32'(i), 0);
    cyc(2'd0, 1, 32'hFEED, 1);
    chk("R11 level", 32'(level), 15);
    chk("R11 overrun", 32'(ovr), 1);
    // R10 mono with one slot left
    do_reset();
    for (int i = 0; i < 15; i++) cyc(2'd0, 1, 32'(i), 0);
    cyc(2'd3, 1, 32'h77, 0);
    chk("R10 mono no room", 32'(level), 15);

    // random phases
    void'($urandom(32'd4242));
    for (int p = 0; p < 8; p++) begin
      do_reset();
      for (int c = 0; c < 300; c++) begin
        logic [1:0] m;
        m = (c % 40 == 0 || p < 4) ? 2'(p % 4) : 2'($urandom_range(0, 3));
        cyc(m, ($urandom_range(0, 99) < 45 + p * 3), $urandom(),
            ($urandom_range(0, 99) < 45), ($urandom_range(0, 19) == 0),
            5'($urandom_range(0, 17)));
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule